// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

A single pulse-width modulation channel built around a down-counter that advances once per tick enable. Software sets the period and the duty point by writing a count buffer and a compare buffer through a small register port. The buffered values do not reach the live counter and compare registers straight away. They are copied at the next cycle boundary, or at once while software holds a manual-update control bit set. Because of this, a new period or duty value never cuts a running cycle short.

The control register holds the enable, manual-update, auto-reload and inversion bits. When the channel is disabled, or when it stops at the end of a single cycle, the output holds the level it had when the last cycle finished. That level is active only if that cycle ran at full duty. A manual update also sets this held level from the newly loaded compare value. As a result, software that lowers the duty from full, forces an update and then disables the channel sees the output go inactive, even if no cycle boundary came in between.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: Writes to the count buffer (address 0) and compare buffer (address 1) read back unchanged from those addresses. They leave the live counter untouched until a cycle boundary or a manual update.
- R2: With enable and auto-reload set, a tick that finds the live counter at zero loads both live registers from the buffers. One period therefore lasts the buffered count plus one ticks.
- R3: Control register at address 2 uses bit 0 enable, bit 1 manual update, bit 2 auto-reload and bit 3 invert. On every clock in which bit 1 is set, both live registers load from the buffers. The block never clears bit 1 by itself.
- R4: A manual update takes priority over counting and over a natural reload. While bit 1 stays set, the live counter holds the buffered count even when the channel is enabled and ticking.
- R5: The live counter decrements by one on each clock in which the tick enable is high and the channel is enabled. It holds when the tick is low or the channel is disabled.
- R6: While the channel runs, the output is active when the live counter is at or below the live compare. A compare of all ones gives full duty.
- R7: While the channel is disabled, the output holds the level of the end of the last cycle: active only if that cycle's compare was all ones. A manual update sets this held level to active only if the new compare is all ones.
- R8: With auto-reload clear, the counter stops at zero after the cycle ends and the output keeps its end-of-cycle level until a manual update.
- R9: The invert bit flips the output polarity, both while running and while holding.
- R10: Address 3 reads the live counter value. Writes to address 3 have no effect.
- R11: After the synchronous reset, all buffers, live registers and the control register are zero, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled tick enable for the counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Registered read data for the previous clock's address |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The counter assertions assume that the control register changes only through the write port, and that the tick enable is a plain level sampled each clock. The stimulus sets new buffer values and toggles the manual bit only through single-clock writes. Duty is judged by counting active samples over windows that are whole multiples of the period, so the start phase does not matter. Live-counter reads are taken only while the tick is low or the counter is stopped or held, so each read sees a settled value.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT  = 2'd0,
    A_CMP  = 2'd1,
    A_CTRL = 2'd2,
    A_LIVE = 2'd3
  } reg_addr_e;

  // packed MSB first: invert=bit3, autoreload=bit2, manual=bit1, enable=bit0
  typedef struct packed {
    logic invert;
    logic autoreload;
    logic manual;
    logic enable;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [CNT_W-1:0]  cnt_buf,
  output logic [CNT_W-1:0]  cmp_buf,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  rdata
);
  localparam int unsigned PAD_W = CNT_W - CTRL_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_buf <= '0;
      cmp_buf <= '0;
      ctrl    <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_CNT:   cnt_buf <= wdata;
        A_CMP:   cmp_buf <= wdata;
        A_CTRL:  ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (reg_addr_e'(addr))
        A_CNT:   rdata <= cnt_buf;
        A_CMP:   rdata <= cmp_buf;
        A_CTRL:  rdata <= {{PAD_W{1'b0}}, ctrl};
        default: rdata <= live_cnt;
      endcase
    end
  end

  // R3: manual bit stays set unless software rewrites the control register
  p_manual_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.manual && !we) |=> ctrl.manual)
    else $error("manual bit cleared without a write");
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_live,
  output logic             run,
  output logic             act,
  output logic             hold_lvl
);
  logic stopped;
  logic step;

  assign run  = ctrl.enable && !stopped;
  assign step = run && tick;
  assign act  = (cnt <= cmp_live);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cmp_live <= '0;
      stopped  <= 1'b0;
      hold_lvl <= 1'b0;
    end else if (ctrl.manual) begin
      cnt      <= cnt_buf;
      cmp_live <= cmp_buf;
      stopped  <= 1'b0;
      hold_lvl <= &cmp_buf;
    end else if (step) begin
      if (cnt == '0) begin
        hold_lvl <= &cmp_live;
        if (ctrl.autoreload) begin
          cnt      <= cnt_buf;
          cmp_live <= cmp_buf;
        end else begin
          stopped  <= 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R3: manual update loads both live registers from the buffers
  p_manual_load_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl.manual |=> (cnt == $past(cnt_buf) && cmp_live == $past(cmp_buf)))
    else $error("manual load mismatch");

  // R1: live compare changes only through a boundary or a manual update
  p_buffer_isolation_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.manual && !(ctrl.enable && tick && cnt == '0)) |=> $stable(cmp_live))
    else $error("live compare changed off boundary");

  // R2: natural reload at the boundary
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.manual && step && cnt == '0 && ctrl.autoreload) |=> cnt == $past(cnt_buf))
    else $error("reload missed");

  // R5: one decrement per tick, hold while disabled
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.manual && step && cnt != '0) |=> cnt == $past(cnt) - 1'b1)
    else $error("bad decrement");

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.manual && !ctrl.enable) |=> $stable(cnt))
    else $error("counter moved while disabled");

  // R8: stopped channel stays at zero without manual update
  p_stop_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.manual && ctrl.enable && !run) |=> cnt == '0)
    else $error("stopped counter left zero");
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic act,
  input  logic hold_lvl,
  input  logic invert,
  output logic pwm_out
);
  logic lvl;

  assign lvl = run ? act : hold_lvl;

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= lvl ^ invert;
  end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             pwm_out
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt_buf, cmp_buf, cnt, cmp_live;
  logic             run, act, hold_lvl;

  pwm_regfile #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .live_cnt(cnt), .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .ctrl(ctrl),
    .rdata(reg_rdata)
  );

  pwm_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .tick(tick_en), .ctrl(ctrl), .cnt_buf(cnt_buf),
    .cmp_buf(cmp_buf), .cnt(cnt), .cmp_live(cmp_live), .run(run), .act(act),
    .hold_lvl(hold_lvl)
  );

  pwm_outstage out_i (
    .clk(clk), .rst(rst), .run(run), .act(act), .hold_lvl(hold_lvl),
    .invert(ctrl.invert), .pwm_out(pwm_out)
  );

  // R9/R7: with inversion clear, a full-duty hold drives the output active
  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && hold_lvl && !ctrl.invert) |=> pwm_out)
    else $error("full-duty hold not active");
endmodule

// File: tb/pwm_dbuf_chan_tb_top.sv
module pwm_dbuf_chan_tb_top;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         pwm_out;

  always #5 clk = ~clk;

  pwm_dbuf_chan #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  typedef struct {
    string        req;
    logic [W-1:0] val;
  } exp_t;

  exp_t         exp_q[$];
  logic [W-1:0] act_q[$];
  int           n_checks = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  // monitor: pops pairs and compares
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t         e;
      logic [W-1:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_checks++;
      if (a !== e.val) begin
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d", e.req, a, e.val);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string req);
    reg_addr = a;
    @(negedge clk);
    act_q.push_back(reg_rdata);
    exp_q.push_back('{req, e});
  endtask

  task automatic measure(input int n, input int e, input string req);
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      c += int'(pwm_out);
    end
    act_q.push_back(W'(c));
    exp_q.push_back('{req, W'(e)});
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R11 reset state
    act_q.push_back(W'(pwm_out)); exp_q.push_back('{"R11 out", '0});
    rd(2'd0, 0, "R11 cnt buf");
    rd(2'd2, 0, "R11 ctrl");
    rd(2'd3, 0, "R11 live");
    // R1 buffers and isolation
    wr(2'd0, 3); wr(2'd1, 1); idle(2);
    rd(2'd0, 3, "R1 cnt buf");
    rd(2'd1, 1, "R1 cmp buf");
    rd(2'd3, 0, "R1 live untouched");
    // R3 manual update, not auto-cleared
    wr(2'd2, 16'h2); idle(2);
    rd(2'd2, 16'h2, "R3 manual sticky");
    rd(2'd3, 3, "R3 manual load");
    wr(2'd2, 16'h0);
    // R10 live is read-only
    wr(2'd3, 16'h55); idle(1);
    rd(2'd3, 3, "R10 live write ignored");
    // R4 manual held while enabled and ticking
    tick_en = 1'b1;
    wr(2'd2, 16'h3); idle(3);
    rd(2'd3, 3, "R4 manual holds count");
    wr(2'd2, 16'h0); tick_en = 1'b0;
    // R6 period 4, active 2
    tick_en = 1'b1;
    wr(2'd2, 16'h5); idle(8);
    measure(40, 20, "R6 duty 2 of 4");
    // R2 new period 5, active 1, taken at boundary
    wr(2'd0, 4); wr(2'd1, 0); idle(12);
    measure(50, 10, "R2 period 5 duty 1");
    // R9 inverted while running
    wr(2'd2, 16'hD); idle(3);
    measure(50, 40, "R9 inverted run");
    // R6 full duty
    wr(2'd2, 16'h5); wr(2'd1, 16'hFFFF); idle(12);
    measure(20, 20, "R6 full duty");
    // R7 disable at full duty holds active
    wr(2'd2, 16'h4); idle(2);
    measure(10, 10, "R7 hold active");
    // R7 manual update with lower duty clears held level
    wr(2'd1, 1); wr(2'd2, 16'h6); wr(2'd2, 16'h4); idle(2);
    measure(10, 0, "R7 manual clears hold");
    // R7 disable at partial duty ends inactive
    wr(2'd0, 3); wr(2'd2, 16'h6); wr(2'd2, 16'h5); idle(10);
    wr(2'd2, 16'h4); idle(2);
    measure(10, 0, "R7 partial duty hold");
    // R9 inverted hold
    wr(2'd2, 16'hC); idle(2);
    measure(10, 10, "R9 inverted hold");
    // R8 single cycle stop
    tick_en = 1'b0;
    wr(2'd0, 2); wr(2'd1, 0); wr(2'd2, 16'h2); wr(2'd2, 16'h1);
    tick_en = 1'b1; idle(10); tick_en = 1'b0; idle(1);
    rd(2'd3, 0, "R8 stopped at zero");
    measure(10, 0, "R8 stopped level");
    // R5 counting only with tick and enable
    wr(2'd0, 5); wr(2'd2, 16'h3); idle(2); wr(2'd2, 16'h1); idle(3);
    rd(2'd3, 5, "R5 hold without tick");
    tick_en = 1'b1; idle(2); tick_en = 1'b0; idle(1);
    rd(2'd3, 3, "R5 two ticks");
    wr(2'd2, 16'h0);
    tick_en = 1'b1; idle(2); tick_en = 1'b0; idle(1);
    rd(2'd3, 3, "R5 disabled hold");
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule